// File: doc/BRIEF.md
# Local Bus Address Decoder

This block sits beside the processor's local bus and turns each transfer's 32-bit address into at most one device select. It does this for a mostly fixed memory map: two boot flash windows, a default onboard SRAM window, a handful of local I/O register blocks, an address-mirrored battery-backed RAM/clock window and a pair of ECC controller register blocks that exist only when a mezzanine card is fitted. A configurable number of DRAM windows and one extra SRAM window are set up by base, compare mask and enable inputs. A window matches when every address bit marked in its mask equals the corresponding bit of its base.

After every reset a boot overlay is armed, and it maps the lowest 2 MB of the address space onto the first boot flash window. Software drops the overlay with a one-cycle clear pulse. From then on the programmable windows may claim the low addresses.

The block also closes each transfer. A claimed access gets a one-cycle acknowledge pulse on the edge after the strobe is first seen. A sub-word write to the local control/status block gets a transfer-error pulse in place of the acknowledge. An unclaimed access is ended with a transfer error by a loadable timeout, or waits indefinitely when the timer is switched off. The master holds the strobe and address steady until it sees a response, then drops the strobe for at least one cycle.

Top module: `lbus_decoder`

## Requirements
- R1: Only transfer-type codes 0, 1 and 2 may produce a select. Any other code yields no select, and the access is treated as unclaimed.
- R2: With strobe high, the following fixed ranges drive the dev_sel bit shown: 0xFF800000–0xFF9FFFFF to bit 0 (flash A), 0xFFA00000–0xFFBFFFFF to bit 1 (flash B), 0xFFE00000–0xFFE1FFFF to bit 2 (SRAM), 0xFFF42000–0xFFF42FFF to bit 3 (board controller), 0xFFF40000–0xFFF400FF to bit 4 (local CSR) and 0xFFF40100–0xFFF401FF to bit 5 (global CSR). The ranges 0xFFC00000–0xFFDFFFFF and 0xFFF00000–0xFFF3FFFF are not decoded.
- R3: Reset arms the boot overlay. While it is armed, addresses 0x00000000–0x001FFFFF select flash A (bit 0). A pulse on ovl_clr disarms it until the next reset.
- R4: DRAM window i drives dram_sel[i] and the programmable SRAM window drives dev_sel bit 2. A window hits when it is enabled and ((addr ^ base) & mask) == 0. The order of precedence is overlay, then fixed map, then DRAM (lowest index first), then the SRAM window.
- R5: At most one bit of {dram_sel, dev_sel} is high at any time.
- R6: Selects are zero while strobe is low. A claimed, legal access gets ack high for exactly the one cycle that follows the first clock edge that sees the strobe. ack and tea are never high together.
- R7: Size codes are 00 byte, 01 halfword, 10 word and 11 reserved. A write to the local CSR block with any size other than 10 ends with tea instead of ack. Writes to the global CSR block and reads of either block are acknowledged at every size.
- R8: Every address in 0xFFFC0000–0xFFFCFFFF selects dev_sel bit 8, so the 8 KB device image repeats through the window.
- R9: When mezz_present is high, 0xFFF43000–0xFFF43FFF selects ECC block 0 (bit 6) if address bit 8 is 0 and ECC block 1 (bit 7) if it is 1. When mezz_present is low, that range is unclaimed.
- R10: An unclaimed access with tmr_en high ends with a one-cycle tea that appears after the (tmr_count+2)-th clock edge, counting the edge that first sees the strobe as the first.
- R11: With tmr_en low, an unclaimed access gets neither ack nor tea for as long as the strobe is held.
- R12: Each access receives at most one response pulse. No further response comes until the strobe has been low for a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 32 | Transfer address |
| size | input | 2 | Transfer size code |
| wr | input | 1 | 1 = write, 0 = read |
| strobe | input | 1 | Transfer in progress, held until response |
| tt | input | 3 | Transfer-type code |
| ovl_clr | input | 1 | One-cycle pulse that disarms the boot overlay |
| mezz_present | input | 1 | ECC mezzanine fitted |
| dram_base | input | NUM_DRAM×32 | Base address per DRAM window |
| dram_mask | input | NUM_DRAM×32 | Compare mask per DRAM window |
| dram_en | input | NUM_DRAM | Enable per DRAM window |
| sram_base | input | 32 | Programmable SRAM window base |
| sram_mask | input | 32 | Programmable SRAM window compare mask |
| sram_en | input | 1 | Programmable SRAM window enable |
| tmr_en | input | 1 | Timeout enable |
| tmr_count | input | CNT_W | Timeout reload value |
| dev_sel | output | 9 | One-hot fixed-device selects |
| dram_sel | output | NUM_DRAM | One-hot DRAM window selects |
| ack | output | 1 | Normal termination pulse |
| tea | output | 1 | Transfer-error termination pulse |

## Verification
If the overlay flag held the wrong value, low addresses would select flash A after the clear pulse, or select DRAM before it. This shows on the select outputs in the same cycle that the strobe rises. If the response state machine entered a wrong state, it would show one edge later as a missing or repeated ack/tea pulse. A timeout counter loaded with the wrong value would only show after tmr_count+2 edges, as a tea that comes early or late, so the bench measures the latency of every unclaimed access cycle by cycle. Precedence faults between overlapping windows are visible only when windows actually overlap, so the configurations deliberately put DRAM, SRAM and fixed ranges on top of one another.

// File: rtl/lbd_pkg.sv
package lbd_pkg;
  localparam int NDEV       = 9;
  localparam int DEV_FLASHA = 0;
  localparam int DEV_FLASHB = 1;
  localparam int DEV_SRAM   = 2;
  localparam int DEV_BCTL   = 3;
  localparam int DEV_LCSR   = 4;
  localparam int DEV_GCSR   = 5;
  localparam int DEV_ECC0   = 6;
  localparam int DEV_ECC1   = 7;
  localparam int DEV_BBRAM  = 8;

  localparam logic [1:0] SZ_WORD  = 2'b10;
  localparam logic [2:0] TT_MAXOK = 3'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } lbd_state_e;
endpackage

// File: rtl/lbd_window.sv
module lbd_window #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  input  logic          en,
  output logic          hit
);
  assign hit = en && (((addr ^ base) & mask) == '0);
endmodule

// File: rtl/lbd_fixed_map.sv
module lbd_fixed_map
  import lbd_pkg::*;
(
  input  logic [31:0]     addr,
  input  logic            mezz_present,
  output logic [NDEV-1:0] hit
);
  logic unused_low;
  assign unused_low = ^addr[7:0];

  always_comb begin
    hit = '0;
    hit[DEV_FLASHA] = (addr[31:21] == 11'h7FC);
    hit[DEV_FLASHB] = (addr[31:21] == 11'h7FD);
    hit[DEV_SRAM]   = (addr[31:17] == 15'h7FF0);
    hit[DEV_BCTL]   = (addr[31:12] == 20'hFFF42);
    hit[DEV_LCSR]   = (addr[31:8]  == 24'hFFF400);
    hit[DEV_GCSR]   = (addr[31:8]  == 24'hFFF401);
    hit[DEV_ECC0]   = mezz_present && (addr[31:12] == 20'hFFF43) && !addr[8];
    hit[DEV_ECC1]   = mezz_present && (addr[31:12] == 20'hFFF43) &&  addr[8];
    hit[DEV_BBRAM]  = (addr[31:16] == 16'hFFFC);
  end
endmodule

// File: rtl/lbd_resp_fsm.sv
module lbd_resp_fsm
  import lbd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstn_s,
  input  logic             strobe,
  input  logic             claimed,
  input  logic             illegal,
  input  logic             tmr_en,
  input  logic [CNT_W-1:0] tmr_count,
  output logic             ack,
  output logic             tea,
  output logic             start,
  output logic             waiting
);
  lbd_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             ack_q, ack_d, tea_q, tea_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    ack_d  = 1'b0;
    tea_d  = 1'b0;
    start  = (st_q == ST_IDLE) && strobe;
    case (st_q)
      ST_IDLE: begin
        if (strobe) begin
          if (claimed) begin
            st_d  = ST_DONE;
            ack_d = !illegal;
            tea_d = illegal;
          end else begin
            st_d   = ST_WAIT;
            cnt_d  = tmr_count;
            cnt_en = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (!strobe) begin
          st_d = ST_IDLE;
        end else if (tmr_en) begin
          if (cnt_q == '0) begin
            tea_d = 1'b1;
            st_d  = ST_DONE;
          end else begin
            cnt_d  = cnt_q - 1'b1;
            cnt_en = 1'b1;
          end
        end
      end
      ST_DONE: begin
        if (!strobe) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
      tea_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= ack_d;
      tea_q <= tea_d;
    end
  end

  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ack     = ack_q;
  assign tea     = tea_q;
  assign waiting = (st_q == ST_WAIT);
endmodule

// File: rtl/lbus_decoder.sv
module lbus_decoder
  import lbd_pkg::*;
#(
  parameter int NUM_DRAM = 2,
  parameter int CNT_W    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [31:0]              addr,
  input  logic [1:0]               size,
  input  logic                     wr,
  input  logic                     strobe,
  input  logic [2:0]               tt,
  input  logic                     ovl_clr,
  input  logic                     mezz_present,
  input  logic [NUM_DRAM-1:0][31:0] dram_base,
  input  logic [NUM_DRAM-1:0][31:0] dram_mask,
  input  logic [NUM_DRAM-1:0]      dram_en,
  input  logic [31:0]              sram_base,
  input  logic [31:0]              sram_mask,
  input  logic                     sram_en,
  input  logic                     tmr_en,
  input  logic [CNT_W-1:0]         tmr_count,
  output logic [NDEV-1:0]          dev_sel,
  output logic [NUM_DRAM-1:0]      dram_sel,
  output logic                     ack,
  output logic                     tea
);
  localparam logic [10:0] OVL_TOP = 11'h000;

  logic [1:0] rst_sync_q;
  logic       rstn_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rstn_s = rst_sync_q[1];

  logic ovl_q;
  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s)      ovl_q <= 1'b1;
    else if (ovl_clr) ovl_q <= 1'b0;
  end

  logic [NDEV-1:0]     fix_hit;
  logic [NUM_DRAM-1:0] dram_hit;
  logic                sram_hit;

  lbd_fixed_map u_fixed (
    .addr         (addr),
    .mezz_present (mezz_present),
    .hit          (fix_hit)
  );

  for (genvar gi = 0; gi < NUM_DRAM; gi++) begin : g_dram
    lbd_window #(.AW(32)) u_win (
      .addr (addr),
      .base (dram_base[gi]),
      .mask (dram_mask[gi]),
      .en   (dram_en[gi]),
      .hit  (dram_hit[gi])
    );
  end

  lbd_window #(.AW(32)) u_sram_win (
    .addr (addr),
    .base (sram_base),
    .mask (sram_mask),
    .en   (sram_en),
    .hit  (sram_hit)
  );

  logic tt_ok, ovl_hit, found;
  assign tt_ok   = (tt <= TT_MAXOK);
  assign ovl_hit = ovl_q && (addr[31:21] == OVL_TOP);

  always_comb begin
    dev_sel  = '0;
    dram_sel = '0;
    found    = 1'b0;
    if (strobe && tt_ok) begin
      if (ovl_hit) begin
        dev_sel[DEV_FLASHA] = 1'b1;
      end else if (|fix_hit) begin
        dev_sel = fix_hit;
      end else if (|dram_hit) begin
        for (int i = 0; i < NUM_DRAM; i++) begin
          if (dram_hit[i] && !found) begin
            dram_sel[i] = 1'b1;
            found       = 1'b1;
          end
        end
      end else if (sram_hit) begin
        dev_sel[DEV_SRAM] = 1'b1;
      end
    end
  end

  logic claimed, illegal, start, waiting;
  assign claimed = (|dev_sel) || (|dram_sel);
  assign illegal = dev_sel[DEV_LCSR] && wr && (size != SZ_WORD);

  lbd_resp_fsm #(.CNT_W(CNT_W)) u_resp (
    .clk       (clk),
    .rstn_s    (rstn_s),
    .strobe    (strobe),
    .claimed   (claimed),
    .illegal   (illegal),
    .tmr_en    (tmr_en),
    .tmr_count (tmr_count),
    .ack       (ack),
    .tea       (tea),
    .start     (start),
    .waiting   (waiting)
  );
endmodule

// File: rtl/lbd_checker.sv
module lbd_checker
  import lbd_pkg::*;
#(
  parameter int NUM_DRAM = 2
) (
  input logic                clk,
  input logic                rstn_s,
  input logic [31:0]         addr,
  input logic [1:0]          size,
  input logic                wr,
  input logic                strobe,
  input logic [2:0]          tt,
  input logic                tmr_en,
  input logic                mezz_present,
  input logic [NDEV-1:0]     dev_sel,
  input logic [NUM_DRAM-1:0] dram_sel,
  input logic                ack,
  input logic                tea,
  input logic                ovl_q,
  input logic                start,
  input logic                waiting
);
  // R1
  p_tt_filter_r1: assert property (@(posedge clk) disable iff (!rstn_s)
    (strobe && tt > 3'd2) |-> (dev_sel == '0 && dram_sel == '0));
  // R3
  p_overlay_r3: assert property (@(posedge clk) disable iff (!rstn_s)
    (strobe && tt <= 3'd2 && ovl_q && addr[31:21] == 11'h000) |-> dev_sel[DEV_FLASHA]);
  // R5
  p_onehot_r5: assert property (@(posedge clk) disable iff (!rstn_s)
    $onehot0({dram_sel, dev_sel}));
  // R6
  p_idle_nosel_r6: assert property (@(posedge clk) disable iff (!rstn_s)
    !strobe |-> (dev_sel == '0 && dram_sel == '0));
  p_excl_resp_r6: assert property (@(posedge clk) disable iff (!rstn_s)
    !(ack && tea));
  // R7
  p_narrow_lcsr_r7: assert property (@(posedge clk) disable iff (!rstn_s)
    (start && dev_sel[DEV_LCSR] && wr && size != SZ_WORD) |=> (tea && !ack));
  // R8
  p_bbram_mirror_r8: assert property (@(posedge clk) disable iff (!rstn_s)
    (strobe && tt <= 3'd2 && addr[31:16] == 16'hFFFC) |-> dev_sel[DEV_BBRAM]);
  // R9
  p_ecc_absent_r9: assert property (@(posedge clk) disable iff (!rstn_s)
    !mezz_present |-> (!dev_sel[DEV_ECC0] && !dev_sel[DEV_ECC1]));
  // R11
  p_timer_off_r11: assert property (@(posedge clk) disable iff (!rstn_s)
    (waiting && !tmr_en) |=> !tea);
  // R12
  p_single_resp_r12: assert property (@(posedge clk) disable iff (!rstn_s)
    (ack || tea) |=> !(ack || tea));
endmodule

bind lbus_decoder lbd_checker #(.NUM_DRAM(NUM_DRAM)) u_chk (
  .clk          (clk),
  .rstn_s       (rstn_s),
  .addr         (addr),
  .size         (size),
  .wr           (wr),
  .strobe       (strobe),
  .tt           (tt),
  .tmr_en       (tmr_en),
  .mezz_present (mezz_present),
  .dev_sel      (dev_sel),
  .dram_sel     (dram_sel),
  .ack          (ack),
  .tea          (tea),
  .ovl_q        (ovl_q),
  .start        (start),
  .waiting      (waiting)
);

// File: tb/lbus_decoder_test.sv
module lbus_decoder_test;
  localparam int ND = 2;
  localparam int CW = 8;
  localparam int B_FA = 0, B_FB = 1, B_SR = 2, B_BC = 3, B_LC = 4,
                 B_GC = 5, B_E0 = 6, B_E1 = 7, B_BB = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [31:0]       addr;
  logic [1:0]        size;
  logic              wr, strobe, ovl_clr, mezz_present;
  logic [2:0]        tt;
  logic [ND-1:0][31:0] dram_base, dram_mask;
  logic [ND-1:0]     dram_en;
  logic [31:0]       sram_base, sram_mask;
  logic              sram_en, tmr_en;
  logic [CW-1:0]     tmr_count;
  logic [8:0]        dev_sel;
  logic [ND-1:0]     dram_sel;
  logic              ack, tea;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic ovl_m;

  always #10 clk = ~clk;

  lbus_decoder #(.NUM_DRAM(ND), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .size(size), .wr(wr),
    .strobe(strobe), .tt(tt), .ovl_clr(ovl_clr), .mezz_present(mezz_present),
    .dram_base(dram_base), .dram_mask(dram_mask), .dram_en(dram_en),
    .sram_base(sram_base), .sram_mask(sram_mask), .sram_en(sram_en),
    .tmr_en(tmr_en), .tmr_count(tmr_count),
    .dev_sel(dev_sel), .dram_sel(dram_sel), .ack(ack), .tea(tea)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h addr=%h", req, act, exp, addr);
    end
  endtask

  function automatic logic in_rng(input logic [31:0] a, input logic [31:0] lo, input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Expected {dram_sel, dev_sel}
  function automatic logic [10:0] route(input logic [31:0] a, input logic [2:0] t, input logic mz);
    logic [10:0] r = '0;
    if (t > 3'd2) return r;
    if (ovl_m && a < 32'h0020_0000)              r[B_FA] = 1'b1;
    else if (in_rng(a, 32'hFF80_0000, 32'hFF9F_FFFF)) r[B_FA] = 1'b1;
    else if (in_rng(a, 32'hFFA0_0000, 32'hFFBF_FFFF)) r[B_FB] = 1'b1;
    else if (in_rng(a, 32'hFFE0_0000, 32'hFFE1_FFFF)) r[B_SR] = 1'b1;
    else if (in_rng(a, 32'hFFF4_2000, 32'hFFF4_2FFF)) r[B_BC] = 1'b1;
    else if (in_rng(a, 32'hFFF4_0000, 32'hFFF4_00FF)) r[B_LC] = 1'b1;
    else if (in_rng(a, 32'hFFF4_0100, 32'hFFF4_01FF)) r[B_GC] = 1'b1;
    else if (mz && in_rng(a, 32'hFFF4_3000, 32'hFFF4_3FFF)) begin
      if (a[8]) r[B_E1] = 1'b1; else r[B_E0] = 1'b1;
    end
    else if (in_rng(a, 32'hFFFC_0000, 32'hFFFC_FFFF)) r[B_BB] = 1'b1;
    else if (dram_en[0] && ((a ^ dram_base[0]) & dram_mask[0]) == 0) r[9] = 1'b1;
    else if (dram_en[1] && ((a ^ dram_base[1]) & dram_mask[1]) == 0) r[10] = 1'b1;
    else if (sram_en && ((a ^ sram_base) & sram_mask) == 0) r[B_SR] = 1'b1;
    return r;
  endfunction

  function automatic string tag_of(input logic [10:0] r, input logic [31:0] a, input logic [2:0] t);
    if (t > 3'd2) return "R1";
    if (r == 0) return "R10";
    if (ovl_m && a < 32'h0020_0000) return "R3";
    if (r[10:9] != 0 || (r[B_SR] && !in_rng(a, 32'hFFE0_0000, 32'hFFE1_FFFF))) return "R4";
    if (r[B_BB]) return "R8";
    if (r[B_E0] || r[B_E1]) return "R9";
    return "R2";
  endfunction

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic w,
                        input logic [2:0] t, input logic mz);
    logic [10:0] exp_r;
    string tg;
    int lat, exp_lat, limit;
    logic exp_tea, none_exp;
    @(negedge clk);
    addr = a; size = sz; wr = w; tt = t; mezz_present = mz; strobe = 1'b1;
    exp_r = route(a, t, mz);
    tg = tag_of(exp_r, a, t);
    #1;
    chk({dram_sel, dev_sel} == exp_r, tg, {21'd0, dram_sel, dev_sel}, {21'd0, exp_r});
    chk($countones({dram_sel, dev_sel}) <= 1, "R5", {21'd0, dram_sel, dev_sel}, 32'd0);
    none_exp = 1'b0;
    if (exp_r != 0) begin
      exp_lat = 1;
      exp_tea = exp_r[B_LC] && w && (sz != 2'b10);
    end else if (tmr_en) begin
      exp_lat = int'(tmr_count) + 2;
      exp_tea = 1'b1;
    end else begin
      exp_lat = 0; exp_tea = 1'b0; none_exp = 1'b1;
    end
    limit = none_exp ? 40 : exp_lat + 4;
    lat = 0;
    do begin
      @(posedge clk); @(negedge clk);
      lat++;
    end while (!(ack || tea) && lat < limit);
    if (none_exp) begin
      chk(!(ack || tea), "R11", {30'd0, ack, tea}, 32'd0);
    end else begin
      chk(lat == exp_lat, (exp_r != 0) ? "R6" : "R10", lat, exp_lat);
      chk(tea == exp_tea && ack == !exp_tea,
          exp_r[B_LC] ? "R7" : ((exp_r != 0) ? "R6" : "R10"),
          {30'd0, ack, tea}, {30'd0, !exp_tea, exp_tea});
      @(negedge clk);
      chk(!(ack || tea), "R12", {30'd0, ack, tea}, 32'd0);
    end
    strobe = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] pick_addr();
    logic [31:0] anchors [14] = '{32'h0000_0000, 32'h0010_0000, 32'h0100_0000, 32'h0200_0000,
                                   32'hFF80_0000, 32'hFFA0_0000, 32'hFFC0_0000, 32'hFFE0_0000,
                                   32'hFFF0_0000, 32'hFFF4_0000, 32'hFFF4_2000, 32'hFFF4_3000,
                                   32'hFFFC_0000, 32'hFFFE_0000};
    return anchors[$urandom % 14] | ($urandom & 32'h0000_3FFF);
  endfunction

  task automatic random_phase(input int n);
    for (int k = 0; k < n; k++) begin
      logic [2:0] t;
      tmr_count = CW'($urandom % 8);
      t = ($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 3);
      access(pick_addr(), 2'($urandom), 1'($urandom), t, 1'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; addr = '0; size = 2'b10; wr = 1'b0; strobe = 1'b0; tt = 3'd0;
    ovl_clr = 1'b0; mezz_present = 1'b1;
    dram_base[0] = 32'h0000_0000; dram_mask[0] = 32'hFF00_0000;
    dram_base[1] = 32'h0100_0000; dram_mask[1] = 32'hFF00_0000;
    dram_en = 2'b11;
    sram_base = 32'h0200_0000; sram_mask = 32'hFFFE_0000; sram_en = 1'b1;
    tmr_en = 1'b1; tmr_count = 8'd3;
    ovl_m = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // Reset state (R6)
    chk(!ack && !tea && dev_sel == 0 && dram_sel == 0, "R6", {21'd0, dram_sel, dev_sel}, 32'd0);

    // R3 overlay armed
    access(32'h0000_1000, 2'b10, 1'b0, 3'd0, 1'b1);
    access(32'h001F_FFFC, 2'b10, 1'b0, 3'd1, 1'b1);
    // R2 fixed map
    access(32'hFF80_1000, 2'b10, 1'b0, 3'd0, 1'b1);
    access(32'hFFA0_0000, 2'b10, 1'b0, 3'd2, 1'b1);
    access(32'hFFE1_FFFC, 2'b10, 1'b1, 3'd0, 1'b1);
    access(32'hFFF4_2010, 2'b00, 1'b1, 3'd0, 1'b1);
    // R7 CSR write sizes
    access(32'hFFF4_0004, 2'b00, 1'b1, 3'd0, 1'b1);
    access(32'hFFF4_0004, 2'b01, 1'b1, 3'd0, 1'b1);
    access(32'hFFF4_0004, 2'b11, 1'b1, 3'd0, 1'b1);
    access(32'hFFF4_0004, 2'b10, 1'b1, 3'd0, 1'b1);
    access(32'hFFF4_00FF, 2'b00, 1'b0, 3'd0, 1'b1);
    access(32'hFFF4_0101, 2'b00, 1'b1, 3'd0, 1'b1);
    // R8 mirrored window
    access(32'hFFFC_2000, 2'b00, 1'b0, 3'd0, 1'b1);
    access(32'hFFFC_E004, 2'b10, 1'b1, 3'd0, 1'b1);
    // R9 ECC blocks
    access(32'hFFF4_3004, 2'b00, 1'b0, 3'd0, 1'b1);
    access(32'hFFF4_3104, 2'b00, 1'b0, 3'd0, 1'b1);
    access(32'hFFF4_3F00, 2'b00, 1'b0, 3'd0, 1'b1);
    tmr_count = 8'd2;
    access(32'hFFF4_3004, 2'b00, 1'b0, 3'd0, 1'b0);
    // R10 timeout on undecoded space
    tmr_count = 8'd5;
    access(32'hFFF0_0010, 2'b10, 1'b0, 3'd0, 1'b1);
    tmr_count = 8'd0;
    access(32'hFFC0_0000, 2'b10, 1'b0, 3'd0, 1'b1);
    // R11 timer off
    tmr_en = 1'b0;
    access(32'hFFD0_0000, 2'b10, 1'b0, 3'd0, 1'b1);
    tmr_en = 1'b1;
    // R1 non-normal transfer type
    tmr_count = 8'd1;
    access(32'hFF80_0000, 2'b10, 1'b0, 3'd7, 1'b1);
    access(32'hFFF4_0000, 2'b10, 1'b0, 3'd3, 1'b1);

    random_phase(120);

    // Disarm overlay (R3), then programmable windows (R4)
    @(negedge clk); ovl_clr = 1'b1;
    @(negedge clk); ovl_clr = 1'b0; ovl_m = 1'b0;
    access(32'h0000_1000, 2'b10, 1'b0, 3'd0, 1'b1);
    access(32'h0100_0040, 2'b10, 1'b0, 3'd0, 1'b1);
    access(32'h0201_FFFC, 2'b10, 1'b0, 3'd0, 1'b1);
    dram_en = 2'b10;
    sram_base = 32'h0000_0000;
    access(32'h0000_1000, 2'b10, 1'b0, 3'd0, 1'b1);
    dram_base[1] = 32'hFFF0_0000; dram_mask[1] = 32'hFFF0_0000;
    access(32'hFFF4_0000, 2'b10, 1'b1, 3'd0, 1'b1);
    access(32'hFFF0_0010, 2'b10, 1'b1, 3'd0, 1'b1);
    dram_base[0] = 32'hFFF0_0000; dram_mask[0] = 32'hFFF0_0000; dram_en = 2'b11;
    access(32'hFFF3_0000, 2'b10, 1'b0, 3'd0, 1'b1);
    dram_base[0] = 32'h0000_0000; dram_mask[0] = 32'hFF00_0000;
    dram_base[1] = 32'h0100_0000; dram_mask[1] = 32'hFF00_0000;
    sram_base = 32'h0200_0000;

    random_phase(150);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule